// File: doc/BRIEF.md
# Modem Status Register with Change Flags

This block is the modem status register of a UART-style serial controller. It watches four active-low modem handshake lines: carrier detect, ring indicator, data set ready and clear to send. Each line passes through a synchroniser and is inverted. The upper nibble of the register shows the present level of each line. The lower nibble holds sticky change flags. A host reads the register over a byte-wide register bus. The read returns the flags as they stood before the read and clears them in the same cycle.

While any change flag is set, the block holds a modem-status interrupt request high. The request is a level, not a pulse.

In loopback mode, bits of the modem control register replace the external lines. Change detection compares levels after this substitution. Switching loopback on or off can therefore raise flags by itself.

Top module: `modem_status_reg`

## Requirements
- R1: Bits 7..4 of the read data show the inverted, synchronised levels of the lines: bit 7 = carrier detect (`lineN[3]`), bit 6 = ring indicator (`lineN[2]`), bit 5 = data set ready (`lineN[1]`), bit 4 = clear to send (`lineN[0]`). A low pin reads as 1. A pin change is visible after `SYNC_STAGES` rising clock edges.
- R2: Bit 3 (carrier detect), bit 1 (data set ready) and bit 0 (clear to send) set when the matching level changes in either direction, and stay set until cleared.
- R3: Bit 2 sets only when the ring indicator level goes from 1 to 0. A 0-to-1 change leaves it unaffected.
- R4: A read is `rdEn` = 1 with `addr` = `STATUS_ADDR` (default 6). Bits 3..0 return the flags as they were before the read and clear at that clock edge. A change detected in the same cycle as the read is kept as a newly set flag.
- R5: `msIrq` is 1 exactly while any of bits 3..0 is 1.
- R6: While `ctrlBits[4]` = 1 (loopback), carrier detect reads `ctrlBits[3]`, ring indicator reads `ctrlBits[2]`, data set ready reads `ctrlBits[0]`, and clear to send reads `ctrlBits[1]`. The external lines are ignored.
- R7: Change detection uses the level after the loopback selection. Entering or leaving loopback sets a flag for every status bit whose level differs between the two sources, following the rules of R2 and R3.
- R8: A write (`wrEn` = 1) to any offset, including `STATUS_ADDR`, changes nothing. `rdData` is 0 whenever no read of `STATUS_ADDR` is in progress.
- R9: After reset, with all pins high and loopback off, the read data is 0x00 and `msIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineN | input | 4 | Active-low modem lines: [3] carrier detect, [2] ring, [1] data set ready, [0] clear to send |
| ctrlBits | input | 5 | Modem control register bits 4..0; bit 4 selects loopback |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe (ignored) |
| addr | input | ADDR_W (3) | Register offset |
| wrData | input | 8 | Write data (ignored) |
| rdData | output | 8 | Read data: levels in [7:4], change flags in [3:0] |
| msIrq | output | 1 | Modem-status interrupt request level |

## Verification
The bench builds the block with its default parameters: `SYNC_STAGES` = 2, `ADDR_W` = 3 and `STATUS_ADDR` = 6. With two synchroniser stages, a pin toggle that lands in the same cycle as a read is easy to stage. This exercises the rule that a flag raised during a read is kept. A three-bit address also lets the bench read and write the neighbouring offsets, to show that those accesses return zero and leave the flags alone. The reference model tracks pin history in a queue, so other stage counts would only shift its latency.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NumLines = 4;
  localparam int IdxCts = 0;
  localparam int IdxDsr = 1;
  localparam int IdxRi  = 2;
  localparam int IdxDcd = 3;

  typedef struct packed {
    logic rdHit;
    logic loopback;
  } msrStrobe_t;
endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int STATUS_ADDR = 6
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              loopBit,
  output msrStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] HitAddr = ADDR_W'(STATUS_ADDR);

  always_comb begin
    strobe.rdHit    = rdEn && (addr == HitAddr);
    strobe.loopback = loopBit;
  end
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumLines-1:0] lineN,
  input  logic [3:0]          loopBits,
  input  msrStrobe_t          strobe,
  output logic [7:0]          rdData,
  output logic                msIrq
);
  logic [NumLines-1:0] syncQ [SYNC_STAGES];
  logic [NumLines-1:0] levelNow;
  logic [NumLines-1:0] levelPrev;
  logic [NumLines-1:0] changeNow;
  logic [NumLines-1:0] flags;
  logic [NumLines-1:0] loopLevel;

  // Synchroniser chain; resets to the inactive (high) pin level.
  genvar st;
  generate
    for (st = 0; st < SYNC_STAGES; st++) begin : g_sync
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= '1;
          else       syncQ[0] <= lineN;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[st] <= '1;
          else       syncQ[st] <= syncQ[st-1];
      end
    end
  endgenerate

  // Loopback remap of control bits onto status positions.
  always_comb begin
    loopLevel[IdxDcd] = loopBits[3];
    loopLevel[IdxRi]  = loopBits[2];
    loopLevel[IdxDsr] = loopBits[0];
    loopLevel[IdxCts] = loopBits[1];
  end

  assign levelNow = strobe.loopback ? loopLevel : ~syncQ[SYNC_STAGES-1];

  always_comb begin
    changeNow         = levelNow ^ levelPrev;
    changeNow[IdxRi]  = levelPrev[IdxRi] & ~levelNow[IdxRi];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelPrev <= '0;
      flags     <= '0;
    end else begin
      levelPrev <= levelNow;
      flags     <= (strobe.rdHit ? '0 : flags) | changeNow;
    end
  end

  assign rdData = strobe.rdHit ? {levelNow, flags} : 8'h00;
  assign msIrq  = |flags;

  // R2: a two-way change on carrier, data set ready or clear to send is latched
  a_r2_delta_latched: assert property (@(posedge clk) disable iff (!rstN)
    (levelNow[IdxDcd] != levelPrev[IdxDcd]) |=> flags[IdxDcd]);
  a_r2_cts_latched: assert property (@(posedge clk) disable iff (!rstN)
    (levelNow[IdxCts] != levelPrev[IdxCts]) |=> flags[IdxCts]);
  // R3: a rising ring level never raises the ring flag on its own
  a_r3_ri_rise_silent: assert property (@(posedge clk) disable iff (!rstN)
    (levelNow[IdxRi] && !levelPrev[IdxRi] && !flags[IdxRi]) |=> !flags[IdxRi]);
  // R4: a read with no concurrent change empties the flags
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdHit && (levelNow == levelPrev)) |=> (flags == '0));
  // R4: a set flag survives any non-read cycle
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rdHit && flags[IdxDsr]) |=> flags[IdxDsr]);
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  parameter int STATUS_ADDR = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        lineN,
  input  logic [4:0]        ctrlBits,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              msIrq
);
  msrStrobe_t strobe;
  logic unusedWrite;

  // R8: the register is read-only; write traffic is consumed here
  assign unusedWrite = wrEn ^ (^wrData);

  msr_ctrl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_ctrl (
    .rdEn    (rdEn),
    .addr    (addr),
    .loopBit (ctrlBits[4]),
    .strobe  (strobe)
  );

  msr_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineN    (lineN),
    .loopBits (ctrlBits[3:0]),
    .strobe   (strobe),
    .rdData   (rdData),
    .msIrq    (msIrq)
  );

  // R5: the request matches the flags returned by a read
  a_r5_irq_follows_flags: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(STATUS_ADDR)) |-> (msIrq == (rdData[3:0] != 4'h0)));
  // R6: loopback levels come from the control bits
  a_r6_loop_levels: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[4] && rdEn && addr == ADDR_W'(STATUS_ADDR)) |->
      (rdData[7:4] == {ctrlBits[3], ctrlBits[2], ctrlBits[0], ctrlBits[1]}));
  // R8: nothing is driven outside a status read
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && addr == ADDR_W'(STATUS_ADDR)) |-> (rdData == 8'h00));
endmodule

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] lineN = 4'hF;
  logic [4:0] ctrlBits = 5'h00;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       msIrq;

  int checks = 0;
  int fails  = 0;
  string curTag = "R9";
  bit done = 1'b0;

  always #5 clk = ~clk;

  modem_status_reg u_dut (
    .clk(clk), .rstN(rstN), .lineN(lineN), .ctrlBits(ctrlBits),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .msIrq(msIrq)
  );

  // Behavioural reference: pin history queue plus previous level and flags
  logic [3:0] pinHist[$];
  logic [3:0] mPrev = 4'h0;
  logic [3:0] mFlags = 4'h0;

  function automatic logic [3:0] modelLevel();
    if (ctrlBits[4])
      return {ctrlBits[3], ctrlBits[2], ctrlBits[0], ctrlBits[1]};
    return ~pinHist[0];
  endfunction

  function automatic bit isRead();
    return rdEn && (addr == 3'd6);
  endfunction

  initial begin
    pinHist.push_back(4'hF);
    pinHist.push_back(4'hF);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      pinHist.delete();
      pinHist.push_back(4'hF);
      pinHist.push_back(4'hF);
      mPrev  = 4'h0;
      mFlags = 4'h0;
    end else begin
      logic [3:0] lvl;
      logic [3:0] chg;
      lvl = modelLevel();
      chg = lvl ^ mPrev;
      chg[2] = mPrev[2] & ~lvl[2];
      mFlags = (isRead() ? 4'h0 : mFlags) | chg;
      mPrev  = lvl;
      pinHist.push_back(lineN);
      void'(pinHist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] expRd;
      logic expIrq;
      expRd  = isRead() ? {modelLevel(), mFlags} : 8'h00;
      expIrq = |mFlags;
      checks++;
      if (rdData !== expRd) begin
        fails++;
        $display("FAIL %s rdData actual=%02h expected=%02h at %0t", curTag, rdData, expRd, $time);
      end
      checks++;
      if (msIrq !== expIrq) begin
        fails++;
        $display("FAIL %s msIrq actual=%0b expected=%0b at %0t", curTag, msIrq, expIrq, $time);
      end
    end
  end

  task automatic drive(input logic [3:0] p, input logic [4:0] c, input logic r,
                       input logic w, input logic [2:0] a, input logic [7:0] d,
                       input string t, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      lineN = p; ctrlBits = c; rdEn = r; wrEn = w; addr = a; wrData = d; curTag = t;
    end
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    drive(4'hF, 5'h00, 1, 0, 3'd6, 8'h00, "R9", 3);
    // R1: level mapping for every pin pattern, read after settling
    for (int v = 0; v < 16; v++) begin
      drive(4'(v), 5'h00, 0, 0, 3'd0, 8'h00, "R1", 3);
      drive(4'(v), 5'h00, 1, 0, 3'd6, 8'h00, "R1", 1);
    end
    drive(4'hF, 5'h00, 1, 0, 3'd6, 8'h00, "R1", 4);
    // R2: carrier, data set ready, clear to send toggles both ways
    drive(4'b0111, 5'h00, 0, 0, 3'd0, 8'h00, "R2", 4);
    drive(4'b0111, 5'h00, 1, 0, 3'd6, 8'h00, "R2", 1);
    drive(4'b1100, 5'h00, 0, 0, 3'd0, 8'h00, "R2", 4);
    drive(4'b1100, 5'h00, 1, 0, 3'd6, 8'h00, "R2", 1);
    drive(4'hF, 5'h00, 0, 0, 3'd0, 8'h00, "R2", 4);
    drive(4'hF, 5'h00, 1, 0, 3'd6, 8'h00, "R2", 1);
    // R3: ring rising edge silent, falling edge flagged
    drive(4'b1011, 5'h00, 0, 0, 3'd0, 8'h00, "R3", 4);
    drive(4'b1011, 5'h00, 1, 0, 3'd6, 8'h00, "R3", 1);
    drive(4'hF, 5'h00, 0, 0, 3'd0, 8'h00, "R3", 4);
    drive(4'hF, 5'h00, 1, 0, 3'd6, 8'h00, "R3", 2);
    // R5: request stays high until read
    drive(4'b1110, 5'h00, 0, 0, 3'd0, 8'h00, "R5", 6);
    drive(4'b1110, 5'h00, 1, 0, 3'd6, 8'h00, "R5", 1);
    drive(4'b1110, 5'h00, 0, 0, 3'd0, 8'h00, "R5", 3);
    // R4: continuous reads while lines toggle every cycle
    for (int k = 0; k < 12; k++)
      drive(4'(k * 5 + 3), 5'h00, 1, 0, 3'd6, 8'h00, "R4", 1);
    drive(4'hF, 5'h00, 0, 0, 3'd0, 8'h00, "R4", 2);
    drive(4'hF, 5'h00, 1, 0, 3'd6, 8'h00, "R4", 3);
    // R8: writes to the status offset and elsewhere, reads of other offsets
    drive(4'hF, 5'h00, 0, 1, 3'd6, 8'hFF, "R8", 2);
    drive(4'hF, 5'h00, 0, 1, 3'd2, 8'h5A, "R8", 1);
    drive(4'b0000, 5'h00, 1, 0, 3'd3, 8'h00, "R8", 4);
    drive(4'b0000, 5'h00, 1, 1, 3'd6, 8'hFF, "R8", 1);
    drive(4'hF, 5'h00, 1, 0, 3'd6, 8'h00, "R8", 4);
    // R7: entering loopback with control bits differing from pins
    drive(4'hF, 5'h1A, 0, 0, 3'd0, 8'h00, "R7", 2);
    drive(4'hF, 5'h1A, 1, 0, 3'd6, 8'h00, "R7", 1);
    // R6: loopback patterns, external lines ignored
    for (int c = 0; c < 16; c++)
      drive(4'(c ^ 4'h9), 5'(16 + c), 1, 0, 3'd6, 8'h00, "R6", 1);
    drive(4'h0, 5'h1F, 1, 0, 3'd6, 8'h00, "R6", 2);
    // R7: leaving loopback onto released pins
    drive(4'hF, 5'h0F, 0, 0, 3'd0, 8'h00, "R7", 2);
    drive(4'hF, 5'h00, 1, 0, 3'd6, 8'h00, "R7", 2);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule